// File: doc/BRIEF.md
# Multi-Sector PIO Data-Phase Sequencer

This block runs the data phase of a disk-style read or write command. A command is launched with a one-cycle start pulse that carries a transfer class, a direction, a sector count and a programmed block size. The block counts 16-bit word strobes from the host into 512-byte sectors. It counts sectors down to zero, and it moves between a busy phase and a data-request phase. Busy means waiting on the media side through `buf_rdy`. Data-request means the host moves words.

Interrupts are placed by class. An ordinary PIO command raises one at every sector, a multiple-mode command raises one at every block, and a DMA-style command raises one only when it completes. A write opens its first data window at once and without an interrupt. After its last sector it waits for the media side before it reports completion. Word strobes outside a data window are discarded and leave a sticky protocol-error flag.

The buffer memory and the media engine sit outside the block. The media engine only has to pulse `buf_rdy` whenever `busy` is high and the next chunk, or the final flush of a write, is ready.

Top module: `pio_xfer_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `drq`, `irq`, `done`, `abort` and `proto_err` are low and `sec_left` is 0.
- R2: At an accepted start, `sec_left` loads the sector count, with a count of 0 meaning 256. It drops by one at each completed sector and reads 0 when `done` pulses.
- R3: A sector completes on exactly the 256th word strobe accepted while `drq` is high. `drq` stays high after 255 of them.
- R4: For a read (`cmd_write`=0), `busy` stays high until `buf_rdy`. In the next cycle `busy` is low, `drq` is high and, for classes other than DMA, `irq` pulses for one cycle.
- R5: Class 1 (multiple) transfers in blocks of `blk_size` sectors. Only 2, 4, 8 and 16 are legal. It raises one interrupt per block start, and the last block holds whatever sectors remain.
- R6: A start with class 3, or with class 1 and an illegal block size, pulses `abort` and `irq` together and transfers nothing. For classes 0 and 2 the block size has no effect.
- R7: Class 2 (DMA) never interrupts between sectors. Its single interrupt pulses together with `done`.
- R8: A write (`cmd_write`=1) raises `drq` in the cycle after start with no interrupt. Each later sector or block start waits for `buf_rdy` and then interrupts (except class 2). After the last sector, `busy` is held until `buf_rdy`, and then `done` and `irq` pulse together.
- R9: A read completes in the cycle after its last word strobe with a `done` pulse. For classes 0 and 1 that completion carries no interrupt.
- R10: A word strobe while `drq` is low changes no count and sets `proto_err`, which holds until the next start in the idle state.
- R11: `busy` and `drq` are never high together, and `done` and `abort` are only ever seen in the idle state.
- R12: Class codes on `cmd_class`: 0 single-sector PIO, 1 multiple-block PIO, 2 DMA, 3 invalid. A start is only accepted while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_start | input | 1 | One-cycle command launch |
| cmd_class | input | 2 | Transfer class (0 single, 1 multiple, 2 DMA, 3 invalid) |
| cmd_write | input | 1 | 1 = host to device, 0 = device to host |
| sec_count | input | 8 | Sectors to move, 0 means 256 |
| blk_size | input | 8 | Programmed sectors per block for class 1 |
| word_stb | input | 1 | One 16-bit word moved on the data port |
| buf_rdy | input | 1 | Media side ready for the next chunk or the flush |
| busy | output | 1 | Waiting on the media side |
| drq | output | 1 | Data window open for word strobes |
| irq | output | 1 | One-cycle interrupt pulse |
| done | output | 1 | One-cycle command completion pulse |
| abort | output | 1 | One-cycle rejection pulse |
| proto_err | output | 1 | Sticky stray-strobe flag |
| sec_left | output | 9 | Sectors still to move |

## Verification
Several properties are checked on every cycle. `busy` and `drq` are never high together. A stray strobe always sets the error flag and never moves the sector count. Any interrupt that is neither a completion nor an abort arrives with an open data window. DMA interrupts only appear with completion. A read window opens exactly as busy falls, and completion always leaves `sec_left` at zero. Interrupt counts per command, the 256-word sector length, the 256-sector meaning of a zero count, block shortening at the tail and the write flush wait depend on whole command histories, so only the bench's scenarios show them.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;

  localparam int SECT_WORDS = 256;
  localparam int CNT_W      = 8;
  localparam int REM_W      = CNT_W + 1;
  localparam int BLK_W      = 8;

  typedef enum logic [1:0] {
    CLS_SINGLE = 2'd0,
    CLS_MULTI  = 2'd1,
    CLS_DMA    = 2'd2,
    CLS_BAD    = 2'd3
  } xfer_cls_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_XFER = 2'd2
  } seq_state_e;

  // Register count to sector total: zero stands for the largest count.
  function automatic logic [REM_W-1:0] full_count(input logic [CNT_W-1:0] sc);
    if (sc == '0) return REM_W'(1 << CNT_W);
    return {1'b0, sc};
  endfunction

  function automatic logic blk_legal(input logic [BLK_W-1:0] b);
    return (b == 8'd2) || (b == 8'd4) || (b == 8'd8) || (b == 8'd16);
  endfunction

  // Sectors in the next data window.
  function automatic logic [REM_W-1:0] chunk_of(input xfer_cls_e cls,
                                                input logic [BLK_W-1:0] blk,
                                                input logic [REM_W-1:0] rem);
    logic [REM_W-1:0] b;
    b = REM_W'(blk);
    if (cls == CLS_MULTI) return (b < rem) ? b : rem;
    return REM_W'(1);
  endfunction

endpackage

// File: rtl/pio_word_ctr.sv
module pio_word_ctr #(
  parameter int WORDS = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic sec_end
);
  localparam int W = $clog2(WORDS);

  logic [W-1:0] cnt;

  assign sec_end = adv && (cnt == W'(WORDS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clr)     cnt <= '0;
    else if (sec_end) cnt <= '0;
    else if (adv)     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pio_sec_ctr.sv
module pio_sec_ctr #(
  parameter int REM_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [REM_W-1:0] full,
  input  logic             chunk_load,
  input  logic [REM_W-1:0] chunk_len,
  input  logic             sec_end,
  output logic [REM_W-1:0] rem,
  output logic             last_sec,
  output logic             chunk_end
);
  logic [REM_W-1:0] chunk_left;

  assign last_sec  = sec_end && (rem == REM_W'(1));
  assign chunk_end = sec_end && (chunk_left == REM_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rem <= '0;
    else if (load)    rem <= full;
    else if (sec_end) rem <= rem - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          chunk_left <= '0;
    else if (chunk_load) chunk_left <= chunk_len;
    else if (sec_end)    chunk_left <= chunk_left - 1'b1;
  end
endmodule

// File: rtl/pio_seq_ctl.sv
module pio_seq_ctl
  import pio_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic [1:0]       cmd_class,
  input  logic             cmd_write,
  input  logic [BLK_W-1:0] blk_size,
  input  logic             buf_rdy,
  input  logic             word_stb,
  input  logic             sec_end,
  input  logic             last_sec,
  input  logic             chunk_end,
  input  logic             rem_zero,
  output seq_state_e       state,
  output xfer_cls_e        cls_q,
  output logic             wr_q,
  output logic [BLK_W-1:0] blk_q,
  output logic             irq,
  output logic             done,
  output logic             abort,
  output logic             proto_err,
  output logic             load,
  output logic             chunk_load,
  output logic             stb_ok
);
  xfer_cls_e cls_in;
  logic      start_bad, start_ok;

  assign cls_in     = xfer_cls_e'(cmd_class);
  assign start_bad  = (cls_in == CLS_BAD) || (cls_in == CLS_MULTI && !blk_legal(blk_size));
  assign start_ok   = (state == ST_IDLE) && cmd_start && !start_bad;
  assign load       = start_ok;
  assign chunk_load = (start_ok && cmd_write) ||
                      ((state == ST_WAIT) && buf_rdy && !rem_zero);
  assign stb_ok     = (state == ST_XFER) && word_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cls_q     <= CLS_SINGLE;
      wr_q      <= 1'b0;
      blk_q     <= '0;
      irq       <= 1'b0;
      done      <= 1'b0;
      abort     <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      irq   <= 1'b0;
      done  <= 1'b0;
      abort <= 1'b0;
      if (cmd_start && state == ST_IDLE) proto_err <= 1'b0;
      if (word_stb && state != ST_XFER)  proto_err <= 1'b1;
      case (state)
        ST_IDLE: if (cmd_start) begin
          if (start_bad) begin
            abort <= 1'b1;
            irq   <= 1'b1;
          end else begin
            cls_q <= cls_in;
            wr_q  <= cmd_write;
            blk_q <= blk_size;
            state <= cmd_write ? ST_XFER : ST_WAIT;
          end
        end
        ST_WAIT: if (buf_rdy) begin
          if (rem_zero) begin
            done  <= 1'b1;
            irq   <= 1'b1;
            state <= ST_IDLE;
          end else begin
            irq   <= (cls_q != CLS_DMA);
            state <= ST_XFER;
          end
        end
        ST_XFER: if (sec_end) begin
          if (last_sec) begin
            if (wr_q) state <= ST_WAIT;
            else begin
              done  <= 1'b1;
              irq   <= (cls_q == CLS_DMA);
              state <= ST_IDLE;
            end
          end else if (chunk_end) begin
            state <= ST_WAIT;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pio_xfer_seq.sv
module pio_xfer_seq
  import pio_seq_pkg::*;
#(
  parameter int WORDS_PER_SEC = SECT_WORDS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic [1:0]       cmd_class,
  input  logic             cmd_write,
  input  logic [CNT_W-1:0] sec_count,
  input  logic [BLK_W-1:0] blk_size,
  input  logic             word_stb,
  input  logic             buf_rdy,
  output logic             busy,
  output logic             drq,
  output logic             irq,
  output logic             done,
  output logic             abort,
  output logic             proto_err,
  output logic [REM_W-1:0] sec_left
);
  seq_state_e       state;
  xfer_cls_e        cls_q, sel_cls;
  logic             wr_q;
  logic [BLK_W-1:0] blk_q, sel_blk;
  logic             load, chunk_load, stb_ok;
  logic             sec_end, last_sec, chunk_end;
  logic [REM_W-1:0] rem, full, sel_rem, chunk_len;
  logic             idle;

  assign idle      = (state == ST_IDLE);
  assign full      = full_count(sec_count);
  assign sel_cls   = idle ? xfer_cls_e'(cmd_class) : cls_q;
  assign sel_blk   = idle ? blk_size : blk_q;
  assign sel_rem   = idle ? full : rem;
  assign chunk_len = chunk_of(sel_cls, sel_blk, sel_rem);

  pio_seq_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_class(cmd_class),
    .cmd_write(cmd_write), .blk_size(blk_size), .buf_rdy(buf_rdy),
    .word_stb(word_stb), .sec_end(sec_end), .last_sec(last_sec),
    .chunk_end(chunk_end), .rem_zero(rem == '0), .state(state),
    .cls_q(cls_q), .wr_q(wr_q), .blk_q(blk_q), .irq(irq), .done(done),
    .abort(abort), .proto_err(proto_err), .load(load),
    .chunk_load(chunk_load), .stb_ok(stb_ok)
  );

  pio_word_ctr #(.WORDS(WORDS_PER_SEC)) u_words (
    .clk(clk), .rst_n(rst_n), .clr(load), .adv(stb_ok), .sec_end(sec_end)
  );

  pio_sec_ctr #(.REM_W(REM_W)) u_secs (
    .clk(clk), .rst_n(rst_n), .load(load), .full(full),
    .chunk_load(chunk_load), .chunk_len(chunk_len), .sec_end(sec_end),
    .rem(rem), .last_sec(last_sec), .chunk_end(chunk_end)
  );

  assign busy     = (state == ST_WAIT);
  assign drq      = (state == ST_XFER);
  assign sec_left = rem;
endmodule

// File: rtl/pio_xfer_seq_chk.sv
module pio_xfer_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_start,
  input logic       word_stb,
  input logic       busy,
  input logic       drq,
  input logic       irq,
  input logic       done,
  input logic       abort,
  input logic       proto_err,
  input logic [8:0] sec_left,
  input logic [1:0] cls_q,
  input logic       wr_q
);
  // R11
  excl_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && drq));

  // R11
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || abort) |-> (!busy && !drq));

  // R10
  stray_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_stb && !drq) |=> proto_err);

  // R10
  stray_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_stb && !drq && !cmd_start) |=> $stable(sec_left));

  // R2
  done_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sec_left == 9'd0));

  // R4
  read_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(drq) && !wr_q) |-> $fell(busy));

  // R5
  irq_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !done && !abort) |-> drq);

  // R7
  dma_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !abort && cls_q == 2'd2) |-> done);

  // R6
  abort_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (irq && !done));
endmodule

bind pio_xfer_seq pio_xfer_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .word_stb(word_stb),
  .busy(busy), .drq(drq), .irq(irq), .done(done), .abort(abort),
  .proto_err(proto_err), .sec_left(sec_left), .cls_q(cls_q), .wr_q(wr_q)
);

// File: tb/pio_xfer_seq_bench.sv
module pio_xfer_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_start = 1'b0;
  logic [1:0] cmd_class = 2'd0;
  logic       cmd_write = 1'b0;
  logic [7:0] sec_count = 8'd0;
  logic [7:0] blk_size = 8'd0;
  logic       word_stb = 1'b0;
  logic       buf_rdy = 1'b0;
  logic       busy, drq, irq, done, abort, proto_err;
  logic [8:0] sec_left;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit reported = 1'b0;

  always #4 clk = ~clk;

  pio_xfer_seq u_pio_xfer_seq (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_class(cmd_class),
    .cmd_write(cmd_write), .sec_count(sec_count), .blk_size(blk_size),
    .word_stb(word_stb), .buf_rdy(buf_rdy), .busy(busy), .drq(drq),
    .irq(irq), .done(done), .abort(abort), .proto_err(proto_err),
    .sec_left(sec_left)
  );

  typedef struct packed {
    logic [1:0] cls;
    logic       wr;
    logic [7:0] sc;
    logic [7:0] blk;
    logic [7:0] irqs;
    logic       abt;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 8'd1,  8'd0,  8'd1,  1'b0},  // R4 single read
    '{2'd0, 1'b0, 8'd3,  8'd0,  8'd3,  1'b0},  // R4 per-sector irq
    '{2'd0, 1'b1, 8'd2,  8'd0,  8'd2,  1'b0},  // R8 single write
    '{2'd1, 1'b0, 8'd6,  8'd4,  8'd2,  1'b0},  // R5 short tail block
    '{2'd1, 1'b1, 8'd5,  8'd2,  8'd3,  1'b0},  // R8 multiple write
    '{2'd2, 1'b0, 8'd3,  8'd0,  8'd1,  1'b0},  // R7 dma read
    '{2'd2, 1'b1, 8'd2,  8'd0,  8'd1,  1'b0},  // R7 dma write
    '{2'd1, 1'b0, 8'd4,  8'd3,  8'd1,  1'b1},  // R6 bad block size
    '{2'd1, 1'b0, 8'd0,  8'd16, 8'd16, 1'b0},  // R2 zero count = 256
    '{2'd1, 1'b0, 8'd20, 8'd8,  8'd3,  1'b0},  // R5 blocks 8,8,4
    '{2'd3, 1'b0, 8'd2,  8'd2,  8'd1,  1'b1},  // R12 invalid class
    '{2'd0, 1'b0, 8'd1,  8'd3,  8'd1,  1'b0}   // R6 blk ignored
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!reported) begin
      reported = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      finish_run();
    end
  end

  task automatic run_vec(input vec_t v);
    int  n_irq = 0;
    int  words = 0;
    int  wait_ctr = 0;
    int  cyc = 0;
    bit  fin = 1'b0;
    bit  seen_done = 1'b0;
    bit  seen_abort = 1'b0;
    int  exp_words;
    exp_words = v.abt ? 0 : ((v.sc == 8'd0) ? 256 : int'(v.sc)) * 256;
    @(negedge clk);
    cmd_class = v.cls; cmd_write = v.wr; sec_count = v.sc; blk_size = v.blk;
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    while (!fin && cyc < 100000) begin
      if (irq)   n_irq++;
      if (done)  seen_done = 1'b1;
      if (abort) seen_abort = 1'b1;
      if (done || abort) fin = 1'b1;
      word_stb = drq && !fin;
      if (word_stb) words++;
      if (busy) wait_ctr++; else wait_ctr = 0;
      buf_rdy = busy && (wait_ctr >= 3);
      cyc++;
      if (!fin) @(negedge clk);
    end
    word_stb = 1'b0;
    buf_rdy  = 1'b0;
    chk(n_irq == int'(v.irqs), "R5/R7/R8 interrupt count", n_irq, int'(v.irqs));
    chk(seen_abort == v.abt, "R6 abort", int'(seen_abort), int'(v.abt));
    chk(seen_done == !v.abt, "R9 completion", int'(seen_done), int'(!v.abt));
    chk(words == exp_words, "R3 words moved", words, exp_words);
    if (!v.abt) chk(sec_left == 9'd0, "R2 count at end", int'(sec_left), 0);
  endtask

  initial begin
    logic [8:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({busy, drq, irq, done, abort, proto_err} == 6'b0, "R1 flags", int'({busy, drq, irq, done, abort, proto_err}), 0);
    chk(sec_left == 9'd0, "R1 sec_left", int'(sec_left), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, drq, irq, done} == 4'b0, "R1 idle after release", int'({busy, drq, irq, done}), 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R10 stray strobe while idle
    @(negedge clk);
    held = sec_left;
    word_stb = 1'b1;
    @(negedge clk);
    word_stb = 1'b0;
    chk(proto_err == 1'b1, "R10 idle stray flag", int'(proto_err), 1);
    chk(sec_left == held, "R10 idle stray count", int'(sec_left), int'(held));

    // single read, two sectors, with a stray strobe while busy
    cmd_class = 2'd0; cmd_write = 1'b0; sec_count = 8'd2; blk_size = 8'd0;
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    chk(proto_err == 1'b0, "R10 flag cleared at start", int'(proto_err), 0);
    chk(busy == 1'b1 && drq == 1'b0, "R4 busy first", int'({busy, drq}), 2);
    chk(sec_left == 9'd2, "R2 loaded count", int'(sec_left), 2);
    word_stb = 1'b1;
    @(negedge clk);
    word_stb = 1'b0;
    chk(proto_err == 1'b1, "R10 busy stray flag", int'(proto_err), 1);
    chk(sec_left == 9'd2 && busy == 1'b1, "R10 busy stray ignored", int'(sec_left), 2);
    buf_rdy = 1'b1;
    @(negedge clk);
    buf_rdy = 1'b0;
    chk(busy == 1'b0 && drq == 1'b1 && irq == 1'b1, "R4 window with irq", int'({busy, drq, irq}), 3);
    word_stb = 1'b1;
    repeat (255) @(negedge clk);
    chk(drq == 1'b1 && sec_left == 9'd2, "R3 open after 255 words", int'(drq), 1);
    @(negedge clk);
    word_stb = 1'b0;
    chk(drq == 1'b0 && busy == 1'b1, "R3 closed after 256 words", int'({busy, drq}), 2);
    chk(sec_left == 9'd1, "R2 decrement", int'(sec_left), 1);
    chk(proto_err == 1'b1, "R10 flag sticky", int'(proto_err), 1);
    buf_rdy = 1'b1;
    @(negedge clk);
    buf_rdy = 1'b0;
    chk(irq == 1'b1 && drq == 1'b1, "R4 second sector irq", int'({drq, irq}), 3);
    word_stb = 1'b1;
    repeat (256) @(negedge clk);
    word_stb = 1'b0;
    chk(done == 1'b1 && irq == 1'b0, "R9 read done without irq", int'({done, irq}), 2);
    chk(sec_left == 9'd0 && drq == 1'b0, "R2 zero at done", int'(sec_left), 0);

    // R12 start while busy is ignored
    cmd_class = 2'd0; cmd_write = 1'b0; sec_count = 8'd1;
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    sec_count = 8'd9;
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    chk(sec_left == 9'd1 && busy == 1'b1, "R12 start ignored when busy", int'(sec_left), 1);
    buf_rdy = 1'b1;
    @(negedge clk);
    buf_rdy = 1'b0;
    word_stb = 1'b1;
    repeat (256) @(negedge clk);
    word_stb = 1'b0;
    chk(done == 1'b1, "R12 first command completes", int'(done), 1);

    finish_run();
  end
endmodule